// File: doc/BRIEF.md
# Grouped-Bus One-Sided Crossbar Arbiter

This block decides, once per clock, which processors may reach which memory modules through a one-sided crossbar. It also picks the shared bus line that carries each connection. The crossbar has `N_PROC` processor ports and `N_MEM` memory ports. They meet on `min(N_PROC, N_MEM)` bus lines, so the switch stays nonblocking. The side with more ports reaches every bus line. The other side is split into `N_GRP` equal groups, and each group can attach only to its own contiguous slice of `N_BUS/N_GRP` bus lines.

Each processor presents a valid bit, a write bit and a target module index. The block answers one clock edge later with a grant, the write bit of the granted request, the chosen bus line and two crosspoint enables: one at the processor port and one at the memory port. Fault mask inputs mark individual crosspoints as broken, and the allocator routes around them. Requests that lose are dropped, so a processor that still wants the module must ask again. Setting `N_GRP` equal to the bus count gives a classic two-sided crossbar. Setting it to one gives a full one-sided crossbar.

Top module: `xbar_grouped_arb`

## Requirements
- R1: While reset is asserted, and in the cycles after it until a request has been accepted, every output is zero.
- R2: The request pattern present before a rising clock edge determines the outputs from that edge until the next one. A request that is no longer presented leaves no grant and no enable behind.
- R3: When several valid requests name the same module in one cycle, only the lowest-numbered processor can be granted. The others get no grant, and each module is granted to at most one processor per cycle.
- R4: With `N_PROC >= N_MEM`, module m belongs to group `m / (N_MEM/N_GRP)` and may use only bus lines `grp*(N_BUS/N_GRP)` to `grp*(N_BUS/N_GRP) + N_BUS/N_GRP - 1`. The chosen line b is reported as a binary number in `grant_bus[p*BW +: BW]`.
- R5: A granted request from processor p to module m closes exactly two crosspoints, `proc_xp_en[p*N_BUS+b]` and `mem_xp_en[m*N_BUS+b]`. It uses the lowest-numbered line in its slice that is free this cycle and healthy at both ends. Processors are served in ascending order when lines are taken.
- R6: A crosspoint whose fault bit (`proc_fault[p*N_BUS+b]` or `mem_fault[m*N_BUS+b]`) is 1 is never closed. The connection moves to the next healthy line instead. Fault bits outside the module's slice have no effect on the result.
- R7: If no free healthy line exists in the slice, the request is rejected with no enables. The module still counts as claimed by that processor, so higher-numbered requesters for it are not granted in that cycle.
- R8: `grant_write[p]` repeats the write bit of processor p's request when p is granted, and is 0 otherwise.
- R9: Each bus line carries at most one connection per cycle. Requests to distinct modules whose lines are healthy are all granted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | N_PROC | Request present, one bit per processor |
| req_write | input | N_PROC | 1 = write, 0 = read, per processor |
| req_target | input | N_PROC*TW | Target module index, TW bits per processor |
| proc_fault | input | N_PROC*N_BUS | 1 marks a broken processor-side crosspoint, bit p*N_BUS+b |
| mem_fault | input | N_MEM*N_BUS | 1 marks a broken memory-side crosspoint, bit m*N_BUS+b |
| grant | output | N_PROC | Registered grant per processor |
| grant_write | output | N_PROC | Registered write bit of the granted request |
| grant_bus | output | N_PROC*BW | Registered bus line index per processor, zero if not granted |
| proc_xp_en | output | N_PROC*N_BUS | Registered processor-side crosspoint enables |
| mem_xp_en | output | N_MEM*N_BUS | Registered memory-side crosspoint enables |

## Verification
The assertions assume the fault mask holds steady over the cycle in which a request is sampled. The faulty-crosspoint property compares the enables against the mask of the previous cycle, so a mask that changes between edges would still be handled correctly by the RTL. The parameters are assumed to meet the divisibility rule, and target indices are assumed to name existing modules. The stimulus drives every input once per cycle at the falling edge. It uses only the default 4x4 geometry, where every 2-bit target is a real module, and keeps random fault masks sparse so that both granted and rejected paths occur.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xbar_rst_sync.sv
module xbar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/xbar_path_alloc.sv
module xbar_path_alloc #(
  parameter int unsigned N_PROC = 4,
  parameter int unsigned N_MEM  = 4,
  parameter int unsigned N_GRP  = 2,
  parameter int unsigned N_BUS  = 4,
  parameter int unsigned TW     = 2,
  parameter int unsigned BW     = 2
) (
  input  logic [N_PROC-1:0]       req_valid,
  input  logic [N_PROC-1:0]       req_write,
  input  logic [N_PROC*TW-1:0]    req_target,
  input  logic [N_PROC*N_BUS-1:0] proc_fault,
  input  logic [N_MEM*N_BUS-1:0]  mem_fault,
  output logic [N_PROC-1:0]       nxt_grant,
  output logic [N_PROC-1:0]       nxt_write,
  output logic [N_PROC*BW-1:0]    nxt_bus,
  output logic [N_PROC*N_BUS-1:0] nxt_pxp,
  output logic [N_MEM*N_BUS-1:0]  nxt_mxp
);
  localparam int unsigned BUS_PER_GRP  = N_BUS / N_GRP;
  localparam int unsigned MEM_PER_GRP  = N_MEM / N_GRP;
  localparam int unsigned PROC_PER_GRP = N_PROC / N_GRP;
  localparam bit          MEM_GROUPED  = (N_PROC >= N_MEM);

  logic [N_MEM-1:0] mod_taken;
  logic [N_BUS-1:0] bus_taken;

  always_comb begin
    int unsigned tgt;
    int unsigned grp;
    int unsigned bl;
    logic        found;
    mod_taken = '0;
    bus_taken = '0;
    nxt_grant = '0;
    nxt_write = '0;
    nxt_bus   = '0;
    nxt_pxp   = '0;
    nxt_mxp   = '0;
    tgt       = 0;
    grp       = 0;
    bl        = 0;
    found     = 1'b0;
    for (int p = 0; p < N_PROC; p++) begin
      if (req_valid[p]) begin
        tgt = int'(req_target[p*TW +: TW]);
        if (tgt < N_MEM && !mod_taken[tgt]) begin
          mod_taken[tgt] = 1'b1;
          found = 1'b0;
          grp = MEM_GROUPED ? (tgt / MEM_PER_GRP) : (p / PROC_PER_GRP);
          for (int k = 0; k < BUS_PER_GRP; k++) begin
            bl = grp * BUS_PER_GRP + k;
            if (!found && !bus_taken[bl] && !proc_fault[p*N_BUS + bl]
                && !mem_fault[tgt*N_BUS + bl]) begin
              found                  = 1'b1;
              bus_taken[bl]          = 1'b1;
              nxt_grant[p]           = 1'b1;
              nxt_write[p]           = req_write[p];
              nxt_bus[p*BW +: BW]    = BW'(bl);
              nxt_pxp[p*N_BUS + bl]  = 1'b1;
              nxt_mxp[tgt*N_BUS + bl] = 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/xbar_grant_reg.sv
module xbar_grant_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/xbar_grouped_arb.sv
module xbar_grouped_arb
  import xbar_pkg::*;
#(
  parameter int unsigned N_PROC = 4,
  parameter int unsigned N_MEM  = 4,
  parameter int unsigned N_GRP  = 2,
  localparam int unsigned N_BUS = min_u(N_PROC, N_MEM),
  localparam int unsigned TW    = idx_w(N_MEM),
  localparam int unsigned BW    = idx_w(N_BUS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_PROC-1:0]       req_valid,
  input  logic [N_PROC-1:0]       req_write,
  input  logic [N_PROC*TW-1:0]    req_target,
  input  logic [N_PROC*N_BUS-1:0] proc_fault,
  input  logic [N_MEM*N_BUS-1:0]  mem_fault,
  output logic [N_PROC-1:0]       grant,
  output logic [N_PROC-1:0]       grant_write,
  output logic [N_PROC*BW-1:0]    grant_bus,
  output logic [N_PROC*N_BUS-1:0] proc_xp_en,
  output logic [N_MEM*N_BUS-1:0]  mem_xp_en
);
  localparam int unsigned SIDE_GRP = (N_PROC >= N_MEM) ? N_MEM : N_PROC;
  localparam int unsigned RW       = 2*N_PROC + N_PROC*BW + N_PROC*N_BUS + N_MEM*N_BUS;

  generate
    if (N_GRP == 0 || (N_BUS % N_GRP) != 0 || (SIDE_GRP % N_GRP) != 0) begin : g_bad_param
      $error("N_GRP must divide both the bus count and the grouped side");
    end
  endgenerate

  logic                    rst_sync_n;
  logic [N_PROC-1:0]       nxt_grant;
  logic [N_PROC-1:0]       nxt_write;
  logic [N_PROC*BW-1:0]    nxt_bus;
  logic [N_PROC*N_BUS-1:0] nxt_pxp;
  logic [N_MEM*N_BUS-1:0]  nxt_mxp;
  logic [RW-1:0]           reg_d;
  logic [RW-1:0]           reg_q;

  xbar_rst_sync rst_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  xbar_path_alloc #(
    .N_PROC(N_PROC), .N_MEM(N_MEM), .N_GRP(N_GRP),
    .N_BUS (N_BUS),  .TW   (TW),    .BW   (BW)
  ) alloc_i (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_target(req_target),
    .proc_fault(proc_fault),
    .mem_fault (mem_fault),
    .nxt_grant (nxt_grant),
    .nxt_write (nxt_write),
    .nxt_bus   (nxt_bus),
    .nxt_pxp   (nxt_pxp),
    .nxt_mxp   (nxt_mxp)
  );

  assign reg_d = {nxt_grant, nxt_write, nxt_bus, nxt_pxp, nxt_mxp};

  xbar_grant_reg #(.WIDTH(RW)) out_reg_i (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .en   (1'b1),
    .d    (reg_d),
    .q    (reg_q)
  );

  assign {grant, grant_write, grant_bus, proc_xp_en, mem_xp_en} = reg_q;
endmodule

// File: rtl/xbar_arb_chk.sv
module xbar_arb_chk
  import xbar_pkg::*;
#(
  parameter int unsigned N_PROC = 4,
  parameter int unsigned N_MEM  = 4,
  parameter int unsigned N_GRP  = 2,
  localparam int unsigned N_BUS = min_u(N_PROC, N_MEM),
  localparam int unsigned TW    = idx_w(N_MEM),
  localparam int unsigned BW    = idx_w(N_BUS)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_PROC-1:0]       req_valid,
  input logic [N_PROC-1:0]       req_write,
  input logic [N_PROC*TW-1:0]    req_target,
  input logic [N_PROC*N_BUS-1:0] proc_fault,
  input logic [N_MEM*N_BUS-1:0]  mem_fault,
  input logic [N_PROC-1:0]       grant,
  input logic [N_PROC-1:0]       grant_write,
  input logic [N_PROC*BW-1:0]    grant_bus,
  input logic [N_PROC*N_BUS-1:0] proc_xp_en,
  input logic [N_MEM*N_BUS-1:0]  mem_xp_en
);
  genvar gp, gb, gm;
  generate
    for (gp = 0; gp < N_PROC; gp++) begin : g_proc
      // R5
      xp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant[gp] |-> $countones(proc_xp_en[gp*N_BUS +: N_BUS]) == 1);
      // R2
      idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant[gp] |-> (proc_xp_en[gp*N_BUS +: N_BUS] == '0 && grant_bus[gp*BW +: BW] == '0
                        && !grant_write[gp]));
      // R2
      grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant[gp] |-> $past(req_valid[gp]));
      // R4
      bus_index_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant[gp] |-> proc_xp_en[gp*N_BUS + int'(grant_bus[gp*BW +: BW])]);
      // R6
      proc_fault_avoid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant[gp] |-> (proc_xp_en[gp*N_BUS +: N_BUS] & $past(proc_fault[gp*N_BUS +: N_BUS])) == '0);
      // R8
      write_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_write[gp] |-> $past(req_write[gp]));
    end

    for (gb = 0; gb < N_BUS; gb++) begin : g_bus
      logic [N_PROC-1:0] pcol;
      logic [N_MEM-1:0]  mcol;
      always_comb begin
        for (int i = 0; i < N_PROC; i++) pcol[i] = proc_xp_en[i*N_BUS + gb];
        for (int j = 0; j < N_MEM; j++)  mcol[j] = mem_xp_en[j*N_BUS + gb];
      end
      // R9
      bus_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pcol) && $onehot0(mcol));
      // R5
      both_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pcol) == $countones(mcol));
    end

    for (gm = 0; gm < N_MEM; gm++) begin : g_mem
      // R3
      module_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_xp_en[gm*N_BUS +: N_BUS]));
      // R6
      mem_fault_avoid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_xp_en[gm*N_BUS +: N_BUS] & $past(mem_fault[gm*N_BUS +: N_BUS])) == '0);
    end
  endgenerate
endmodule

bind xbar_grouped_arb xbar_arb_chk #(
  .N_PROC(N_PROC), .N_MEM(N_MEM), .N_GRP(N_GRP)
) chk_i (.*);

// File: tb/xbar_grouped_arb_tb_top.sv
module xbar_grouped_arb_tb_top;
  localparam int NP = 4;
  localparam int NM = 4;
  localparam int NG = 2;
  localparam int NB = 4;
  localparam int TW = 2;
  localparam int BW = 2;

  typedef struct packed {
    logic [NP-1:0]    g;
    logic [NP-1:0]    w;
    logic [NP*BW-1:0] bi;
    logic [NP*NB-1:0] px;
    logic [NM*NB-1:0] mx;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    req_valid = '0;
  logic [NP-1:0]    req_write = '0;
  logic [NP*TW-1:0] req_target = '0;
  logic [NP*NB-1:0] proc_fault = '0;
  logic [NM*NB-1:0] mem_fault = '0;
  logic [NP-1:0]    grant;
  logic [NP-1:0]    grant_write;
  logic [NP*BW-1:0] grant_bus;
  logic [NP*NB-1:0] proc_xp_en;
  logic [NM*NB-1:0] mem_xp_en;

  int n_chk = 0;
  int n_bad = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  xbar_grouped_arb #(.N_PROC(NP), .N_MEM(NM), .N_GRP(NG)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_target(req_target), .proc_fault(proc_fault), .mem_fault(mem_fault),
    .grant(grant), .grant_write(grant_write), .grant_bus(grant_bus),
    .proc_xp_en(proc_xp_en), .mem_xp_en(mem_xp_en));

  function automatic exp_t model(input logic [NP-1:0] v, input logic [NP-1:0] w,
                                 input logic [NP*TW-1:0] t, input logic [NP*NB-1:0] pf,
                                 input logic [NM*NB-1:0] mf);
    exp_t e;
    logic [NM-1:0] claimed;
    logic [NB-1:0] used;
    e = '0; claimed = '0; used = '0;
    for (int p = 0; p < NP; p++) begin
      if (v[p]) begin
        int m;
        int first;
        logic done;
        m = int'(t[p*TW +: TW]);
        if (!claimed[m]) begin
          claimed[m] = 1'b1;
          done = 1'b0;
          first = (m / (NM/NG)) * (NB/NG);
          for (int b = first; b < first + NB/NG; b++) begin
            if (!done && !used[b] && !pf[p*NB+b] && !mf[m*NB+b]) begin
              done = 1'b1; used[b] = 1'b1;
              e.g[p] = 1'b1; e.w[p] = w[p];
              e.bi[p*BW +: BW] = BW'(b);
              e.px[p*NB+b] = 1'b1; e.mx[m*NB+b] = 1'b1;
            end
          end
        end
      end
    end
    return e;
  endfunction

  task automatic drive(input logic [NP-1:0] v, input logic [NP-1:0] w,
                       input logic [NP*TW-1:0] t, input logic [NP*NB-1:0] pf,
                       input logic [NM*NB-1:0] mf, input string tag);
    @(negedge clk);
    req_valid = v; req_write = w; req_target = t; proc_fault = pf; mem_fault = mf;
    exp_q.push_back(model(v, w, t, pf, mf));
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      exp_t a;
      string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      a = {grant, grant_write, grant_bus, proc_xp_en, mem_xp_en};
      n_chk++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s actual=%h expected=%h", tg, a, e);
      end
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: outputs stay zero in reset even with requests present
    req_valid = 4'hF;
    repeat (3) @(negedge clk);
    n_chk++;
    if ({grant, grant_write, grant_bus, proc_xp_en, mem_xp_en} !== '0) begin
      n_bad++;
      $display("FAIL R1 actual=%h expected=0", {grant, grant_write, grant_bus, proc_xp_en, mem_xp_en});
    end
    req_valid = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_chk++;
    if (grant !== '0 || proc_xp_en !== '0 || mem_xp_en !== '0) begin
      n_bad++;
      $display("FAIL R1 actual=%h expected=0", grant);
    end

    // target field: processor p at bits [2p+1:2p]
    drive(4'b0001, 4'b0001, 8'h00, '0, '0, "R5");          // p0->m0 bus0
    drive(4'b0000, 4'b0000, 8'h00, '0, '0, "R2");          // drop: nothing left
    drive(4'b0010, 4'b0000, 8'h08, '0, '0, "R4");          // p1->m2 bus2
    drive(4'b1000, 4'b1000, 8'hC0, '0, '0, "R4");          // p3->m3 bus2
    drive(4'b0101, 4'b0100, 8'h11, '0, '0, "R3");          // p0,p2->m1: p0 wins
    drive(4'b1111, 4'b1010, 8'hE4, '0, '0, "R9");          // all distinct
    drive(4'b0011, 4'b0011, 8'h04, '0, '0, "R5");          // p0->m0,p1->m1 buses 0,1
    drive(4'b0011, 4'b0001, 8'h04, 16'h0001, '0, "R6");    // p0 bus0 broken
    drive(4'b0001, 4'b0000, 8'h00, '0, 16'h000C, "R6");    // m0 faults outside slice
    drive(4'b0001, 4'b0001, 8'h00, '0, 16'h0003, "R7");    // m0 slice dead
    drive(4'b0011, 4'b0011, 8'h00, 16'h0003, '0, "R7");    // p0 blocked, p1 not given m0
    drive(4'b0110, 4'b0110, 8'h2C, '0, '0, "R8");          // write echo
    drive(4'b0000, 4'b0000, 8'h00, '0, '0, "R2");

    for (int i = 0; i < 300; i++) begin
      drive(4'($urandom), 4'($urandom), 8'($urandom),
            16'($urandom & $urandom & $urandom), 16'($urandom & $urandom & $urandom), "R5");
    end
    drive('0, '0, '0, '0, '0, "R2");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule